// File: doc/BRIEF.md
# Suspend/Wake Event Input Controller

This block watches a bank of edge-sensitive event inputs and turns their edges into power-state requests and interrupts. It runs from a slow 32 kHz clock. Each input is brought into the clock domain by a two-stage synchronizer. An edge detector then applies a per-pin polarity. Each detected edge sets a sticky status bit. It can also ask the power sequencer to suspend, to wake, or to toggle between the two. The block keeps its own awake/suspended state. A request that would not change that state is absorbed and does not reach the sequencer.

The highest-numbered pin can be switched into pushbutton mode. In that mode its level passes through a debounce filter that accepts a new level only after it has held steady for a programmable number of clocks. In pushbutton mode only its falling edge counts, and each press flips the power state.

Interrupts are the OR of the status bits whose enable is set. They are routed either to an active-high SMI line or to an active-low SMBus alert line. They stay asserted until software clears the enabled status bits with a write-one-to-clear strobe. There is no data stream here. Every pin is a plain control or status level, except the two request outputs, which are single-cycle pulses with no handshake. The sequencer must accept a pulse in the cycle it appears.

Top module: `sw_event_ctrl`

## Requirements
- R1: After reset the status register is zero, the block is in the suspended state (`wake_o`=0), `smi_o`=0, `alert_n_o`=1, and no request pulse is issued.
- R2: Polarity bit 0 selects the falling edge (the reset default configuration) and 1 selects the rising edge. The opposite edge sets no status and issues no request.
- R3: Every detected edge sets its pin's status bit, whatever the pin's action. A bit stays set until a 1 is written to the same position of `clr_i`. Clearing one bit leaves the others unchanged, and a new edge in the clearing cycle wins.
- R4: An edge on a pin with action code 1 (suspend), while awake, issues exactly one `susp_req_o` pulse and drives `wake_o` low.
- R5: An edge on a pin with action code 2 (wake), while suspended, issues exactly one `wake_req_o` pulse and drives `wake_o` high.
- R6: A wake edge while awake, a suspend edge while suspended, or an edge with action code 0 sets status only and issues no pulse.
- R7: Action code 3 (toggle) flips the power state on every edge and issues the matching request pulse.
- R8: The interrupt is pending while any status bit with its enable set is 1. With `route_i`=0 it drives `smi_o` high; with `route_i`=1 it drives `alert_n_o` low. The unselected line stays inactive, and a status bit whose enable is clear raises no interrupt.
- R9: With `btn_en_i`=1, the top pin is debounced. A level held for fewer than DEB_CYCLES clocks is ignored, and only its falling edge is detected. That edge acts as a toggle regardless of the pin's polarity and action fields.
- R10: Outputs derived from an input edge change on the third rising clock edge after the input change: two synchronizer stages, then the status/state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32 kHz operating clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | NPINS | Raw event inputs |
| pol_i | input | NPINS | Per-pin edge polarity, 0 falling, 1 rising |
| act_i | input | 2*NPINS | Per-pin action code at bits [2i+1:2i]: 0 none, 1 suspend, 2 wake, 3 toggle |
| ien_i | input | NPINS | Per-pin interrupt enable |
| btn_en_i | input | 1 | Top pin works as a debounced pushbutton |
| route_i | input | 1 | Interrupt route, 0 SMI line, 1 SMBus alert line |
| clr_i | input | NPINS | Write-one-to-clear strobe for status bits |
| susp_req_o | output | 1 | One-cycle suspend request to the sequencer |
| wake_req_o | output | 1 | One-cycle wake request to the sequencer |
| wake_o | output | 1 | High while the block is in the awake state |
| smi_o | output | 1 | Active-high SMI interrupt |
| alert_n_o | output | 1 | Active-low SMBus alert interrupt |
| status_o | output | NPINS | Sticky event status bits |

## Verification
Every pin is swept under both polarities and both edge directions. A design that swapped the polarity sense, or set the wrong bit, would show a status word other than the single expected bit. Redundant wake and suspend edges are replayed after the state has already moved, so a design that re-issued requests would raise the pulse count. The interrupt is probed on both routes, and after clearing only a non-enabled bit, so a design that deasserted too early or drove both lines would be caught. The pushbutton gets a glitch shorter than the debounce window and a release edge. A filter that passed short pulses, or a detector that acted on the release, would change status or toggle the state.

// File: rtl/swev_pkg.sv
package swev_pkg;
  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_SUSPEND = 2'd1,
    ACT_WAKE    = 2'd2,
    ACT_TOGGLE  = 2'd3
  } swev_act_e;
endpackage

// File: rtl/swev_debounce.sv
module swev_debounce #(
  parameter int DEB_CYCLES = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic lvl_o
);
  localparam int CW = (DEB_CYCLES > 2) ? $clog2(DEB_CYCLES) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(DEB_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else if (lvl_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LIMIT) begin
      cnt_q <= '0;
      lvl_q <= lvl_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lvl_o = lvl_q;

  AST_DEB_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lvl_q) |-> $past(cnt_q) == LIMIT); // R9
endmodule

// File: rtl/swev_edge_bank.sv
module swev_edge_bank #(
  parameter int NPINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] evt_i,
  input  logic [NPINS-1:0] pol_i,
  input  logic             btn_en_i,
  input  logic             deb_lvl_i,
  output logic             btn_sync_o,
  output logic [NPINS-1:0] hit_o
);
  logic [NPINS-1:0] s1_q, s2_q, prev_q, lvl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '1;
      s2_q   <= '1;
      prev_q <= '1;
    end else begin
      s1_q   <= evt_i;
      s2_q   <= s1_q;
      prev_q <= lvl;
    end
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    logic rise, fall;
    if (i == NPINS - 1) begin : g_btn
      assign lvl[i]   = btn_en_i ? deb_lvl_i : s2_q[i];
      assign rise     = lvl[i] & ~prev_q[i];
      assign fall     = ~lvl[i] & prev_q[i];
      assign hit_o[i] = btn_en_i ? fall : (pol_i[i] ? rise : fall);
    end else begin : g_plain
      assign lvl[i]   = s2_q[i];
      assign rise     = lvl[i] & ~prev_q[i];
      assign fall     = ~lvl[i] & prev_q[i];
      assign hit_o[i] = pol_i[i] ? rise : fall;
    end
  end

  assign btn_sync_o = s2_q[NPINS-1];
endmodule

// File: rtl/swev_ctrl.sv
module swev_ctrl
  import swev_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NPINS-1:0]   hit_i,
  input  logic [2*NPINS-1:0] act_i,
  input  logic [NPINS-1:0]   ien_i,
  input  logic               btn_en_i,
  input  logic               route_i,
  input  logic [NPINS-1:0]   clr_i,
  output logic               susp_req_o,
  output logic               wake_req_o,
  output logic               wake_o,
  output logic               smi_o,
  output logic               alert_n_o,
  output logic [NPINS-1:0]   status_o
);
  swev_act_e        act_eff [NPINS];
  logic [NPINS-1:0] want_s, want_w;
  logic [NPINS-1:0] status_q;
  logic             awake_q, go_s, go_w, irq;

  for (genvar i = 0; i < NPINS; i++) begin : g_act
    if (i == NPINS - 1) begin : g_btn
      assign act_eff[i] = btn_en_i ? ACT_TOGGLE : swev_act_e'(act_i[2*i +: 2]);
    end else begin : g_plain
      assign act_eff[i] = swev_act_e'(act_i[2*i +: 2]);
    end
    assign want_s[i] = hit_i[i] & ((act_eff[i] == ACT_SUSPEND) | (act_eff[i] == ACT_TOGGLE));
    assign want_w[i] = hit_i[i] & ((act_eff[i] == ACT_WAKE)    | (act_eff[i] == ACT_TOGGLE));

    AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(status_q[i] && !clr_i[i]) |-> status_q[i]); // R3
  end

  assign go_s = awake_q & (|want_s);
  assign go_w = ~awake_q & (|want_w);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q   <= '0;
      awake_q    <= 1'b0;
      susp_req_o <= 1'b0;
      wake_req_o <= 1'b0;
    end else begin
      status_q   <= (status_q & ~clr_i) | hit_i;
      susp_req_o <= go_s;
      wake_req_o <= go_w;
      if (go_s)      awake_q <= 1'b0;
      else if (go_w) awake_q <= 1'b1;
    end
  end

  assign irq       = |(status_q & ien_i);
  assign smi_o     = irq & ~route_i;
  assign alert_n_o = ~(irq & route_i);
  assign wake_o    = awake_q;
  assign status_o  = status_q;

  AST_SUSP_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_req_o |-> !wake_o && $past(awake_q)); // R4
  AST_WAKE_MOVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_req_o |-> wake_o && !$past(awake_q)); // R5
  AST_ONE_REQUEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(susp_req_o && wake_req_o)); // R6
  AST_ONE_ROUTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(smi_o && !alert_n_o)); // R8
endmodule

// File: rtl/sw_event_ctrl.sv
module sw_event_ctrl #(
  parameter int NPINS      = 8,
  parameter int DEB_CYCLES = 512
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NPINS-1:0]   evt_i,
  input  logic [NPINS-1:0]   pol_i,
  input  logic [2*NPINS-1:0] act_i,
  input  logic [NPINS-1:0]   ien_i,
  input  logic               btn_en_i,
  input  logic               route_i,
  input  logic [NPINS-1:0]   clr_i,
  output logic               susp_req_o,
  output logic               wake_req_o,
  output logic               wake_o,
  output logic               smi_o,
  output logic               alert_n_o,
  output logic [NPINS-1:0]   status_o
);
  logic             btn_sync, deb_lvl;
  logic [NPINS-1:0] hit;

  swev_edge_bank #(.NPINS(NPINS)) u_edges (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .pol_i(pol_i),
    .btn_en_i(btn_en_i), .deb_lvl_i(deb_lvl), .btn_sync_o(btn_sync), .hit_o(hit)
  );

  swev_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(btn_sync), .lvl_o(deb_lvl)
  );

  swev_ctrl #(.NPINS(NPINS)) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(hit), .act_i(act_i), .ien_i(ien_i),
    .btn_en_i(btn_en_i), .route_i(route_i), .clr_i(clr_i),
    .susp_req_o(susp_req_o), .wake_req_o(wake_req_o), .wake_o(wake_o),
    .smi_o(smi_o), .alert_n_o(alert_n_o), .status_o(status_o)
  );
endmodule

// File: tb/sw_event_ctrl_bench.sv
module sw_event_ctrl_bench;
  localparam int N   = 8;
  localparam int DEB = 8;

  logic clk = 0, rst_n = 0;
  logic [N-1:0]   evt = '1, pol = '0, ien = '0, clr = '0;
  logic [2*N-1:0] act = '0;
  logic btn_en = 0, route = 0;
  logic susp_req_o, wake_req_o, wake_o, smi_o, alert_n_o;
  logic [N-1:0] status_o;
  int n_s = 0, n_w = 0, base_s, base_w;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sw_event_ctrl #(.NPINS(N), .DEB_CYCLES(DEB)) u_sw_event_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .pol_i(pol), .act_i(act),
    .ien_i(ien), .btn_en_i(btn_en), .route_i(route), .clr_i(clr),
    .susp_req_o(susp_req_o), .wake_req_o(wake_req_o), .wake_o(wake_o),
    .smi_o(smi_o), .alert_n_o(alert_n_o), .status_o(status_o)
  );

  always @(posedge clk) if (rst_n) begin
    if (susp_req_o) n_s <= n_s + 1;
    if (wake_req_o) n_w <= n_w + 1;
  end

  task automatic chk(bit ok, string tag, int actual, int expected);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
    end
  endtask
  task automatic eq(string tag, int actual, int expected);
    chk(actual == expected, tag, actual, expected);
  endtask
  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic drive(int i, logic v); evt[i] = v; tick(4); endtask
  task automatic clear_all(); clr = '1; tick(1); clr = '0; tick(1); endtask
  task automatic mark(); base_s = n_s; base_w = n_w; endtask
  task automatic set_act(int i, int a); act[2*i +: 2] = 2'(a); endtask
  task automatic fall(int i); drive(i, 0); drive(i, 1); endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(2);
    // R1 reset state
    eq("R1 status", status_o, 0);
    eq("R1 wake_o", wake_o, 0);
    eq("R1 smi_o", smi_o, 0);
    eq("R1 alert_n_o", alert_n_o, 1);
    eq("R1 no pulses", n_s + n_w, 0);

    // R2/R3 sweep every pin under both polarities
    mark();
    for (int i = 0; i < N; i++) begin
      for (int p = 0; p < 2; p++) begin
        pol[i] = p[0];
        clear_all();
        drive(i, 0);
        eq(p ? "R2 falling ignored" : "R2 falling seen", status_o, p ? 0 : (1 << i));
        clear_all();
        drive(i, 1);
        eq(p ? "R2 rising seen" : "R2 rising ignored", status_o, p ? (1 << i) : 0);
      end
      pol[i] = 0;
    end
    eq("R6 no request for action none", (n_s - base_s) + (n_w - base_w), 0);

    // R10 latency: status updates on third rising edge
    clear_all();
    evt[1] = 0;
    tick(2);
    eq("R10 not yet after two edges", status_o, 0);
    tick(1);
    eq("R10 set after three edges", status_o, 2);
    evt[1] = 1; tick(4);

    // R3 selective clear
    clear_all();
    fall(0); fall(6);
    clr = 8'h01; tick(1); clr = '0; tick(1);
    eq("R3 selective clear", status_o, 8'h40);

    // R5/R6 wake path
    clear_all(); mark();
    set_act(3, 2); set_act(4, 1); set_act(5, 3);
    fall(3);
    eq("R5 wake pulse", n_w - base_w, 1);
    eq("R5 wake_o", wake_o, 1);
    fall(3);
    eq("R6 redundant wake", n_w - base_w, 1);
    eq("R6 status still set", status_o[3], 1);
    // R4/R6 suspend path
    fall(4);
    eq("R4 suspend pulse", n_s - base_s, 1);
    eq("R4 wake_o low", wake_o, 0);
    fall(4);
    eq("R6 redundant suspend", n_s - base_s, 1);

    // R7 toggle
    mark();
    for (int k = 1; k <= 4; k++) begin
      fall(5);
      eq("R7 toggle state", wake_o, k % 2);
      eq("R7 toggle pulses", (n_s - base_s) + (n_w - base_w), k);
    end
    act = '0;

    // R8 interrupt routing and hold
    clear_all();
    ien[2] = 1; route = 0;
    fall(1);
    eq("R8 non-enabled bit no smi", smi_o, 0);
    fall(2);
    eq("R8 smi asserted", smi_o, 1);
    eq("R8 alert idle on smi route", alert_n_o, 1);
    route = 1; tick(1);
    eq("R8 alert asserted", alert_n_o, 0);
    eq("R8 smi idle on alert route", smi_o, 0);
    clr = 8'h02; tick(1); clr = '0; tick(1);
    eq("R8 held after non-enabled clear", alert_n_o, 0);
    clr = 8'h04; tick(1); clr = '0; tick(1);
    eq("R8 released after clear", alert_n_o, 1);
    ien = '0; route = 0;

    // R9 pushbutton
    btn_en = 1; pol[7] = 1; set_act(7, 0);
    clear_all(); mark();
    evt[7] = 0; tick(DEB / 2); evt[7] = 1; tick(DEB + 6);
    eq("R9 glitch ignored", status_o, 0);
    evt[7] = 0; tick(DEB + 6);
    eq("R9 press sets status", status_o, 8'h80);
    eq("R9 press wakes", wake_o, 1);
    clear_all();
    evt[7] = 1; tick(DEB + 6);
    eq("R9 release ignored", status_o, 0);
    evt[7] = 0; tick(DEB + 6);
    eq("R9 second press suspends", wake_o, 0);
    eq("R9 pulse counts", (n_s - base_s) * 10 + (n_w - base_w), 11);
    evt[7] = 1; tick(DEB + 6);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule